// File: doc/BRIEF.md
# Program Fetch Bus Sequencer

This block sits between a CPU's instruction-fetch port and a program memory that may be on the chip or outside it. The CPU offers a 15-bit byte address with a request while the block reports ready. The block then either reads a synchronous on-chip ROM port or runs a fixed, clock-counted external cycle on a multiplexed bus. The external cycle puts the low address byte on an 8-bit shared bus and pulses a latch strobe. It keeps the upper seven address bits on their own port, frees the shared bus, and drops an active-low read strobe. The byte returned by the external memory is captured on the clock edge that ends the strobe.

A strap input, sampled only while reset is held, chooses the memory map. With the strap high, the lower 16 KB of the 32 KB space is served on chip and the upper half goes external. With the strap low, every fetch goes external. In either case the fetched byte comes back with a one-cycle valid pulse. A new request may be presented in that same cycle.

Top module: `pfetch_bus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `fetch_ready`=1, `addr_latch`=0, `rd_strobe_n`=1, `bus_oe`=0, `fetch_valid`=0 and `rom_en`=0.
- R2: `int_rom_pin` is sampled only while `rst` is high. A low value sends every fetch external. A change after reset has no effect on routing.
- R3: With the strap high, an address below 0x4000 is read on chip. `rom_en` is high for one cycle, with `rom_addr` equal to the address. The strobes and `bus_oe` stay inactive. `fetch_valid` rises on the third cycle after the accepting edge, carrying the `rom_data` value that the ROM returns one edge after `rom_en`.
- R4: With the strap high, an address of 0x4000 or above (address bit 14 set) is fetched externally.
- R5: An external fetch raises `addr_latch` for 2 cycles, starting the cycle after acceptance. During that time `bus_oe`=1 and `bus_out` holds address bits 7:0. `addr_hi` holds address bits 14:8 for the whole fetch.
- R6: After `addr_latch` falls, `bus_oe` and `bus_out` are held for one more cycle. `bus_oe` is then low for one full cycle before `rd_strobe_n` falls.
- R7: `rd_strobe_n` is low for 2 cycles, starting the fifth cycle after acceptance. It is never low while `addr_latch` or `bus_oe` is high.
- R8: `bus_in` is captured on the edge where `rd_strobe_n` returns high. `fetch_valid` is high for exactly the following cycle (the seventh after acceptance), with `fetch_data` equal to that byte and `fetch_ready` high.
- R9: `fetch_req` and `fetch_addr` are ignored while `fetch_ready` is low. They change neither the byte returned nor start a second fetch.
- R10: A request presented in the cycle where `fetch_valid` is high is accepted on the next edge, with the same latency as from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also strap sampling window |
| int_rom_pin | input | 1 | Strap: 1 = on-chip ROM serves lower half, 0 = all external |
| fetch_req | input | 1 | Fetch request, taken when fetch_ready is high |
| fetch_addr | input | 15 | Program byte address |
| fetch_ready | output | 1 | Sequencer idle, request can be taken |
| fetch_data | output | 8 | Fetched instruction byte |
| fetch_valid | output | 1 | One-cycle pulse qualifying fetch_data |
| rom_en | output | 1 | On-chip ROM read enable |
| rom_addr | output | 15 | On-chip ROM read address |
| rom_data | input | 8 | On-chip ROM read data, one edge after rom_en |
| bus_out | output | 8 | Shared bus drive value (low address byte) |
| bus_oe | output | 1 | Shared bus output enable |
| bus_in | input | 8 | Shared bus sampled value (instruction byte) |
| addr_hi | output | 7 | Upper address bits for external memory |
| addr_latch | output | 1 | Address latch strobe, active high |
| rd_strobe_n | output | 1 | External program read strobe, active low |

## Verification
The return of one byte and the acceptance of the next request can fall in the same cycle. This is provoked by raising a request exactly in the cycle `fetch_valid` is high, after an external fetch and after an on-chip fetch. The check is that the byte just returned is correct and that the next fetch starts with unchanged latency and strobe timing. A second overlap is a request held while an external cycle is in flight. It is judged by the first byte staying correct and no strobe or ROM enable appearing afterwards.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROM_REQ,
    ST_ROM_DATA,
    ST_LATCH,
    ST_HOLD,
    ST_TURN,
    ST_READ
  } fetch_st_t;
endpackage

// File: rtl/pfetch_strap.sv
module pfetch_strap (
  input  logic clk,
  input  logic rst,
  input  logic strap_in,
  output logic all_ext
);
  // captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) all_ext <= !strap_in;
  end
endmodule

// File: rtl/pfetch_region.sv
module pfetch_region #(
  parameter int ADDR_W    = 15,
  parameter int INT_BYTES = 16384
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              all_ext,
  output logic              go_ext
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(INT_BYTES);

  always_comb go_ext = all_ext || ({1'b0, addr} >= LIMIT);
endmodule

// File: rtl/pfetch_seq.sv
module pfetch_seq
  import pfetch_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int BUS_W    = 8,
  parameter int LAT_CYC  = 2,
  parameter int HOLD_CYC = 1,
  parameter int READ_CYC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                go_ext,
  output logic                ready,
  output logic [BUS_W-1:0]    dout,
  output logic                valid,
  output logic                rom_en,
  output logic [ADDR_W-1:0]   rom_addr,
  input  logic [BUS_W-1:0]    rom_data,
  output logic [BUS_W-1:0]    bus_out,
  output logic                bus_oe,
  input  logic [BUS_W-1:0]    bus_in,
  output logic [ADDR_W-BUS_W-1:0] hi,
  output logic                ale,
  output logic                rd_n
);
  localparam int MAX_A = (LAT_CYC > HOLD_CYC) ? LAT_CYC : HOLD_CYC;
  localparam int MAX_C = (MAX_A > READ_CYC) ? MAX_A : READ_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  fetch_st_t        state;
  logic [CNT_W-1:0] cnt;

  assign ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ale      <= 1'b0;
      rd_n     <= 1'b1;
      bus_oe   <= 1'b0;
      bus_out  <= '0;
      hi       <= '0;
      rom_en   <= 1'b0;
      rom_addr <= '0;
      dout     <= '0;
      valid    <= 1'b0;
    end else begin
      valid  <= 1'b0;
      rom_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            if (go_ext) begin
              state   <= ST_LATCH;
              cnt     <= CNT_W'(LAT_CYC - 1);
              ale     <= 1'b1;
              bus_oe  <= 1'b1;
              bus_out <= addr[BUS_W-1:0];
              hi      <= addr[ADDR_W-1:BUS_W];
            end else begin
              state    <= ST_ROM_REQ;
              rom_en   <= 1'b1;
              rom_addr <= addr;
            end
          end
        end
        ST_ROM_REQ: state <= ST_ROM_DATA;
        ST_ROM_DATA: begin
          dout  <= rom_data;
          valid <= 1'b1;
          state <= ST_IDLE;
        end
        ST_LATCH: begin
          if (cnt == '0) begin
            ale   <= 1'b0;
            state <= ST_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            bus_oe <= 1'b0;
            state  <= ST_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          rd_n  <= 1'b0;
          state <= ST_READ;
          cnt   <= CNT_W'(READ_CYC - 1);
        end
        ST_READ: begin
          if (cnt == '0) begin
            rd_n  <= 1'b1;
            dout  <= bus_in;
            valid <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfetch_bus_ctrl.sv
module pfetch_bus_ctrl #(
  parameter int ADDR_W    = 15,
  parameter int BUS_W     = 8,
  parameter int INT_BYTES = 16384,
  parameter int LAT_CYC   = 2,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    int_rom_pin,
  input  logic                    fetch_req,
  input  logic [ADDR_W-1:0]       fetch_addr,
  output logic                    fetch_ready,
  output logic [BUS_W-1:0]        fetch_data,
  output logic                    fetch_valid,
  output logic                    rom_en,
  output logic [ADDR_W-1:0]       rom_addr,
  input  logic [BUS_W-1:0]        rom_data,
  output logic [BUS_W-1:0]        bus_out,
  output logic                    bus_oe,
  input  logic [BUS_W-1:0]        bus_in,
  output logic [ADDR_W-BUS_W-1:0] addr_hi,
  output logic                    addr_latch,
  output logic                    rd_strobe_n
);
  logic all_ext;
  logic go_ext;

  pfetch_strap u_strap (
    .clk      (clk),
    .rst      (rst),
    .strap_in (int_rom_pin),
    .all_ext  (all_ext)
  );

  pfetch_region #(.ADDR_W(ADDR_W), .INT_BYTES(INT_BYTES)) u_region (
    .addr    (fetch_addr),
    .all_ext (all_ext),
    .go_ext  (go_ext)
  );

  pfetch_seq #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .LAT_CYC(LAT_CYC),
    .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (fetch_req),
    .addr     (fetch_addr),
    .go_ext   (go_ext),
    .ready    (fetch_ready),
    .dout     (fetch_data),
    .valid    (fetch_valid),
    .rom_en   (rom_en),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .bus_in   (bus_in),
    .hi       (addr_hi),
    .ale      (addr_latch),
    .rd_n     (rd_strobe_n)
  );
endmodule

// File: rtl/pfetch_bus_ctrl_chk.sv
module pfetch_bus_ctrl_chk #(
  parameter int HI_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_ready,
  input logic            fetch_valid,
  input logic            rom_en,
  input logic            bus_oe,
  input logic [HI_W-1:0] addr_hi,
  input logic            addr_latch,
  input logic            rd_strobe_n
);
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(addr_latch && !rd_strobe_n));
  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_oe && !rd_strobe_n));
  p_latch_drives_r5: assert property (@(posedge clk) disable iff (rst)
    addr_latch |-> bus_oe);
  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_strobe_n) |-> !$past(bus_oe));
  p_hi_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_n |-> $stable(addr_hi));
  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe_n) |-> fetch_valid);
  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);
  p_valid_ready_r8: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> fetch_ready);
  p_rom_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    rom_en |-> (rd_strobe_n && !addr_latch && !bus_oe));
endmodule

bind pfetch_bus_ctrl pfetch_bus_ctrl_chk #(.HI_W(ADDR_W - BUS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_ready (fetch_ready),
  .fetch_valid (fetch_valid),
  .rom_en      (rom_en),
  .bus_oe      (bus_oe),
  .addr_hi     (addr_hi),
  .addr_latch  (addr_latch),
  .rd_strobe_n (rd_strobe_n)
);

// File: tb/sim_pfetch_bus_ctrl.sv
`timescale 1ns/1ps
module sim_pfetch_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_rom_pin = 1'b1;
  logic        fetch_req = 1'b0;
  logic [14:0] fetch_addr = '0;
  logic        fetch_ready, fetch_valid, rom_en, bus_oe, addr_latch, rd_strobe_n;
  logic [7:0]  fetch_data, bus_out, bus_in;
  logic [7:0]  rom_q = '0;
  logic [14:0] rom_addr;
  logic [6:0]  addr_hi;
  logic [7:0]  lat_lo = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;

  pfetch_bus_ctrl u0 (
    .clk(clk), .rst(rst), .int_rom_pin(int_rom_pin),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data), .fetch_valid(fetch_valid),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_q),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .addr_hi(addr_hi), .addr_latch(addr_latch), .rd_strobe_n(rd_strobe_n)
  );

  function automatic logic [7:0] rom_fn(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] ext_fn(input logic [14:0] a);
    return a[7:0] + {1'b0, a[14:8]} + 8'h91;
  endfunction

  // on-chip ROM model: one edge latency
  always @(posedge clk) if (rom_en) rom_q <= rom_fn(rom_addr);
  // external address latch and memory
  always @(negedge addr_latch) lat_lo = bus_out;
  assign bus_in = rd_strobe_n ? 8'h00 : ext_fn({addr_hi, lat_lo});

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // measured quantities of one fetch
  int m_ale, m_rd, m_first_rd, m_last_oe, m_vk, m_rom, m_lo_bad, m_hi_bad;
  logic [7:0] m_data;

  task automatic issue(input logic [14:0] a);
    fetch_req  = 1'b1;
    fetch_addr = a;
    @(posedge clk);
  endtask

  task automatic measure(input logic [14:0] a, input bit meddle);
    m_ale = 0; m_rd = 0; m_first_rd = 0; m_last_oe = 0; m_vk = 0;
    m_rom = 0; m_lo_bad = 0; m_hi_bad = 0; m_data = '0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 1) fetch_req = 1'b0;
      if (meddle && k == 2) begin fetch_req = 1'b1; fetch_addr = 15'h0123; end
      if (meddle && k == 4) fetch_req = 1'b0;
      if (addr_latch) begin
        m_ale++;
        if (bus_out != a[7:0]) m_lo_bad++;
      end
      if (!rd_strobe_n) begin
        m_rd++;
        if (m_first_rd == 0) m_first_rd = k;
      end
      if (bus_oe) m_last_oe = k;
      if (rom_en) begin
        m_rom++;
        if (rom_addr != a) m_lo_bad++;
      end
      if ((addr_latch || !rd_strobe_n) && addr_hi != a[14:8]) m_hi_bad++;
      if (fetch_valid) begin m_vk = k; m_data = fetch_data; break; end
    end
  endtask

  task automatic judge(input logic [14:0] a, input bit ext, input string tag);
    if (ext) begin
      chk({tag, " R4 R8 ext byte"}, m_data, ext_fn(a));
      chk({tag, " R8 ext latency"}, m_vk, 7);
      chk({tag, " R5 latch width"}, m_ale, 2);
      chk({tag, " R5 low/high address"}, m_lo_bad + m_hi_bad, 0);
      chk({tag, " R6 bus hold then release"}, m_last_oe, 3);
      chk({tag, " R7 read strobe start"}, m_first_rd, 5);
      chk({tag, " R7 read strobe width"}, m_rd, 2);
      chk({tag, " R4 no rom access"}, m_rom, 0);
    end else begin
      chk({tag, " R3 rom byte"}, m_data, rom_fn(a));
      chk({tag, " R3 rom latency"}, m_vk, 3);
      chk({tag, " R3 rom enable once"}, m_rom, 1);
      chk({tag, " R3 strobes quiet"}, m_ale + m_rd + m_last_oe + m_lo_bad, 0);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1;
    int_rom_pin = strap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // {expect external, address}
  localparam logic [15:0] VEC [8] = '{
    16'h0000, 16'h3FFF, 16'hC000, 16'hFFFF,
    16'h1234, 16'hDA5A, 16'h00FF, 16'hC001
  };

  bit done = 1'b0;

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 ready in reset", fetch_ready, 1);
    chk("R1 strobes idle in reset", {addr_latch, rd_strobe_n, bus_oe, fetch_valid, rom_en}, 5'b01000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {fetch_ready, addr_latch, rd_strobe_n, bus_oe, fetch_valid}, 5'b10100);

    // table walk with strap high
    foreach (VEC[i]) begin
      @(negedge clk);
      issue(VEC[i][14:0]);
      measure(VEC[i][14:0], 1'b0);
      judge(VEC[i][14:0], VEC[i][15], "table");
    end

    // R9: requests during an external fetch are ignored
    @(negedge clk);
    issue(15'h6001);
    measure(15'h6001, 1'b1);
    judge(15'h6001, 1'b1, "R9 busy");
    begin
      int stray = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (addr_latch || rom_en || !fetch_ready) stray++;
      end
      chk("R9 no extra fetch", stray, 0);
    end

    // R10: back-to-back in the valid cycle, ext -> rom -> ext
    @(negedge clk);
    issue(15'h7ABC);
    measure(15'h7ABC, 1'b0);
    judge(15'h7ABC, 1'b1, "R10 first");
    issue(15'h0456);
    measure(15'h0456, 1'b0);
    judge(15'h0456, 1'b0, "R10 second");
    issue(15'h4321);
    measure(15'h4321, 1'b0);
    judge(15'h4321, 1'b1, "R10 third");

    // R2: strap low at reset forces external, later changes ignored
    do_reset(1'b0);
    int_rom_pin = 1'b1;
    @(negedge clk);
    issue(15'h0010);
    measure(15'h0010, 1'b0);
    judge(15'h0010, 1'b1, "R2 strap low");
    do_reset(1'b1);
    int_rom_pin = 1'b0;
    @(negedge clk);
    issue(15'h0020);
    measure(15'h0020, 1'b0);
    judge(15'h0020, 1'b0, "R2 strap high");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule